// File: doc/BRIEF.md
# Power Mode and Reset-Kind Control Register

This block is the byte-wide power-management control register of a small 8-bit microcontroller core. It holds two serial-mode bits, a flag that records whether the last reset was a power-on reset, two general-purpose software flags, and the idle and power-down request bits. The idle and power-down bits drive registered status outputs that the clock-gating logic around the core uses. The two serial-mode bits are also brought out directly for the serial port.

The block has two synchronous, active-high reset inputs. A cold (power-on) reset clears the register and sets the power-off flag. A warm reset clears every bit except the power-off flag, which keeps its value. Firmware can therefore clear the flag after start-up and read it back after the next reset to tell which kind of reset occurred. An interrupt-accepted pulse ends idle mode. Power-down mode ends only on a reset.

Top module: `pwr_ctl_reg`

## Requirements
- R1: After a cycle with `cold_rst` high, `rd_data` reads 8'h10 (only bit 4, the power-off flag, set), and `idle_o` and `pdown_o` are 0.
- R2: After a cycle with `warm_rst` high and `cold_rst` low, every bit of `rd_data` except bit 4 is 0, and bit 4 keeps the value it had before that cycle.
- R3: A write (`wr_en` high, no reset) loads bit 7 (double baud rate), bit 6 (framing-error select), bit 4 (power-off flag), bit 3 and bit 2 (general flags) from `wr_data`, and they read back unchanged on `rd_data` at the same positions.
- R4: Bit 5 of `rd_data` always reads 0, and writing 1 to bit 5 has no effect.
- R5: Writing 1 to bit 1 (power-down) sets `pdown_o` and `rd_data[1]` in the cycle after the write. Writing 0 to bit 1 clears them.
- R6: Writing 1 to bit 0 (idle) with bit 1 at 0 sets `idle_o` and `rd_data[0]` in the cycle after the write.
- R7: An `irq_ack` pulse without a write or reset clears bit 0 and `idle_o` and leaves every other bit of `rd_data` unchanged.
- R8: `irq_ack` does not clear power-down: `pdown_o` and `rd_data[1]` keep their value.
- R9: When bits 1 and 0 are both set, `pdown_o` is 1 and `idle_o` is 0.
- R10: When a write and `irq_ack` fall in the same cycle, the written value of bit 0 is the one that takes effect.
- R11: `cold_rst` takes precedence over `warm_rst` and over a write in the same cycle. During either reset, writes are ignored.
- R12: `dbl_baud_o` equals `rd_data[7]` and `fe_sel_o` equals `rd_data[6]` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous power-on reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | One-cycle pulse when the core accepts an interrupt |
| rd_data | output | 8 | Current register contents |
| idle_o | output | 1 | Idle mode active (registered) |
| pdown_o | output | 1 | Power-down mode active (registered) |
| dbl_baud_o | output | 1 | Serial double-baud-rate select |
| fe_sel_o | output | 1 | Serial framing-error select |

## Verification
Every result of this block is due exactly one clock edge after its cause. This covers the read-back of a write, the clearing of idle by an interrupt acceptance, the reset values, and both status outputs, which are registered from the same next-state value as the bits. The bench drives each stimulus on a falling edge, lets one rising edge pass, and samples at the following falling edge. No result is looked for earlier or later than that. The sweep covers all 256 write values, each followed by an interrupt acceptance, a warm reset and a cold reset, and each step is checked at that single point.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  localparam int REG_W    = 8;
  localparam int B_DBLBD  = 7;
  localparam int B_FESEL  = 6;
  localparam int B_RSVD   = 5;
  localparam int B_PWROFF = 4;
  localparam int B_FLAG1  = 3;
  localparam int B_FLAG0  = 2;
  localparam int B_PDOWN  = 1;
  localparam int B_IDLE   = 0;
  localparam int SW_W     = 4;  // serial pair plus general flag pair

  typedef struct packed {
    logic idle;
    logic pdown;
  } mode_t;
endpackage

// File: rtl/pwr_sw_field.sv
// Software-owned bits, cleared by either reset.
module pwr_sw_field #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (clr)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/pwr_off_flag.sv
// Reset-kind flag: set by power-on reset, untouched by warm reset.
module pwr_off_flag (
  input  logic clk,
  input  logic cold,
  input  logic ld,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (cold)    q <= 1'b1;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
// Idle and power-down request bits with registered status outputs.
module pwr_mode_ctl
  import pwr_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  clr,
  input  logic  ld,
  input  mode_t wr_mode,
  input  logic  irq_ack,
  output mode_t mode_q,
  output logic  idle_o,
  output logic  pdown_o
);
  mode_t mode_n;

  always_comb begin
    mode_n = mode_q;
    if (irq_ack) mode_n.idle = 1'b0;
    if (ld)      mode_n = wr_mode;
    if (clr)     mode_n = '0;
  end

  always_ff @(posedge clk) begin
    mode_q  <= mode_n;
    pdown_o <= mode_n.pdown;
    idle_o  <= mode_n.idle & ~mode_n.pdown;
  end
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             cold_rst,
  input  logic             warm_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_ack,
  output logic [REG_W-1:0] rd_data,
  output logic             idle_o,
  output logic             pdown_o,
  output logic             dbl_baud_o,
  output logic             fe_sel_o
);
  logic            any_rst;
  logic            wr_ok;
  logic [SW_W-1:0] sw_d;
  logic [SW_W-1:0] sw_q;
  logic            pwroff_q;
  mode_t           wr_mode;
  mode_t           mode_q;

  assign any_rst = cold_rst | warm_rst;
  assign wr_ok   = wr_en & ~any_rst;

  assign sw_d = {wr_data[B_DBLBD], wr_data[B_FESEL],
                 wr_data[B_FLAG1], wr_data[B_FLAG0]};

  assign wr_mode.idle  = wr_data[B_IDLE];
  assign wr_mode.pdown = wr_data[B_PDOWN];

  pwr_sw_field #(.W(SW_W)) u_sw (
    .clk (clk),
    .clr (any_rst),
    .ld  (wr_ok),
    .d   (sw_d),
    .q   (sw_q)
  );

  pwr_off_flag u_pof (
    .clk  (clk),
    .cold (cold_rst),
    .ld   (wr_ok),
    .d    (wr_data[B_PWROFF]),
    .q    (pwroff_q)
  );

  pwr_mode_ctl u_mode (
    .clk     (clk),
    .clr     (any_rst),
    .ld      (wr_ok),
    .wr_mode (wr_mode),
    .irq_ack (irq_ack),
    .mode_q  (mode_q),
    .idle_o  (idle_o),
    .pdown_o (pdown_o)
  );

  always_comb begin
    rd_data           = '0;
    rd_data[B_DBLBD]  = sw_q[3];
    rd_data[B_FESEL]  = sw_q[2];
    rd_data[B_RSVD]   = 1'b0;
    rd_data[B_PWROFF] = pwroff_q;
    rd_data[B_FLAG1]  = sw_q[1];
    rd_data[B_FLAG0]  = sw_q[0];
    rd_data[B_PDOWN]  = mode_q.pdown;
    rd_data[B_IDLE]   = mode_q.idle;
  end

  assign dbl_baud_o = sw_q[3];
  assign fe_sel_o   = sw_q[2];
endmodule

// File: rtl/pwr_ctl_reg_chk.sv
module pwr_ctl_reg_chk (
  input logic       clk,
  input logic       cold_rst,
  input logic       warm_rst,
  input logic       wr_en,
  input logic       irq_ack,
  input logic [7:0] rd_data,
  input logic       idle_o,
  input logic       pdown_o
);
  // R1
  a_r1_cold_value: assert property (@(posedge clk)
    cold_rst |=> (rd_data == 8'h10 && !idle_o && !pdown_o));

  // R2
  a_r2_warm_keeps_pof: assert property (@(posedge clk) disable iff (cold_rst)
    warm_rst |=> ((rd_data & 8'hEF) == 8'h00 && rd_data[4] == $past(rd_data[4])));

  // R5
  a_r5_pd_status: assert property (@(posedge clk) disable iff (cold_rst)
    ##1 (pdown_o == rd_data[1]));

  // R7
  a_r7_irq_clears_idle: assert property (@(posedge clk) disable iff (cold_rst)
    (irq_ack && !warm_rst && !wr_en) |=> (!idle_o && rd_data[0] == 1'b0));

  // R8
  a_r8_pd_survives_irq: assert property (@(posedge clk) disable iff (cold_rst)
    (irq_ack && !warm_rst && !wr_en && pdown_o) |=> pdown_o);

  // R9
  a_r9_pd_over_idle: assert property (@(posedge clk) disable iff (cold_rst)
    ##1 (rd_data[1] |-> !idle_o));
endmodule

bind pwr_ctl_reg pwr_ctl_reg_chk u_chk (
  .clk      (clk),
  .cold_rst (cold_rst),
  .warm_rst (warm_rst),
  .wr_en    (wr_en),
  .irq_ack  (irq_ack),
  .rd_data  (rd_data),
  .idle_o   (idle_o),
  .pdown_o  (pdown_o)
);

// File: tb/pwr_ctl_reg_tb.sv
module pwr_ctl_reg_tb;
  logic       clk = 1'b0;
  logic       cold_rst = 1'b1;
  logic       warm_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq_ack = 1'b0;
  logic [7:0] rd_data;
  logic       idle_o, pdown_o, dbl_baud_o, fe_sel_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_ctl_reg u_dut (
    .clk        (clk),
    .cold_rst   (cold_rst),
    .warm_rst   (warm_rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .irq_ack    (irq_ack),
    .rd_data    (rd_data),
    .idle_o     (idle_o),
    .pdown_o    (pdown_o),
    .dbl_baud_o (dbl_baud_o),
    .fe_sel_o   (fe_sel_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cold_rst = 1'b0; warm_rst = 1'b0; wr_en = 1'b0; irq_ack = 1'b0;
  endtask

  // expected status from a register image
  task automatic chk_all(input string tag, input logic [7:0] e);
    chk({tag, " rd_data"}, rd_data, e);
    chk({tag, " R5 pdown_o"}, {7'd0, pdown_o}, {7'd0, e[1]});
    chk({tag, " R6 R9 idle_o"}, {7'd0, idle_o}, {7'd0, e[0] & ~e[1]});
    chk({tag, " R12 serial"}, {6'd0, dbl_baud_o, fe_sel_o}, {6'd0, e[7], e[6]});
  endtask

  initial begin
    logic [7:0] img;
    @(negedge clk);
    step();
    chk_all("R1 cold reset", 8'h10);

    for (int v = 0; v < 256; v++) begin
      wr_en = 1'b1; wr_data = 8'(v);
      step();
      img = 8'(v) & 8'hDF;
      chk_all("R3 R4 R5 R6 write", img);
      irq_ack = 1'b1;
      step();
      img[0] = 1'b0;
      chk_all("R7 R8 irq_ack", img);
      warm_rst = 1'b1; wr_en = 1'b1; wr_data = 8'hFF;
      step();
      chk_all("R2 R11 warm reset", img & 8'h10);
      cold_rst = 1'b1; warm_rst = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
      step();
      chk_all("R1 R11 cold reset", 8'h10);
    end

    // R10: write and irq_ack together, write wins
    wr_en = 1'b1; wr_data = 8'h01;
    step();
    wr_en = 1'b1; wr_data = 8'h01; irq_ack = 1'b1;
    step();
    chk_all("R10 write sets idle over ack", 8'h01);
    wr_en = 1'b1; wr_data = 8'h03; irq_ack = 1'b1;
    step();
    chk_all("R10 R9 write both over ack", 8'h03);
    irq_ack = 1'b1;
    step();
    chk_all("R8 pd held after ack", 8'h02);
    wr_en = 1'b1; wr_data = 8'h00;
    step();
    chk_all("R5 pd cleared by write", 8'h00);
    warm_rst = 1'b1;
    step();
    chk_all("R2 warm keeps cleared pof", 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule